// File: doc/BRIEF.md
# Blinking One-Bit Cursor Overlay

This block draws a small monochrome pointer on top of an already composited video stream. It keeps a private bitmap with one bit per cursor pixel. A rectangular window with a programmable width, height and top-left corner places the bitmap anywhere on the panel. Wherever the raster position falls inside that window and the matching bitmap bit is set, the block replaces the incoming pixel with a programmable cursor colour. Pixels whose bit is clear, and pixels outside the window, pass through unchanged. The cursor is never blended: a drawn cursor pixel always replaces whatever lies beneath it.

An optional blink timer counts frame-start pulses. It toggles the cursor between shown and hidden every programmable number of frames. A single write port loads both the control registers and the bitmap words. The pixel path is a fixed two-stage pipeline. The valid strobe travels with the colour, so the display timing logic downstream needs only a fixed delay.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, `out_valid` and `out_pix` are 0 and the cursor is disabled, so pixels pass through unchanged until software sets the enable bit.
- R2: `out_valid` and `out_pix` for a pixel presented with `pix_valid` high appear exactly two clock edges later.
- R3: With the cursor enabled and visible, a pixel inside the window whose bitmap bit is 1 is output as the 24-bit cursor colour, held in bits 23:0 of register 3.
- R4: A pixel inside the window whose bitmap bit is 0 is output equal to `pix_in`.
- R5: The window spans pos_x <= x < pos_x+width and pos_y <= y < pos_y+height. Pixels outside it pass through unchanged.
- R6: While the enable bit (register 0, bit 0) is 0, every pixel passes through unchanged.
- R7: The bitmap index of a pixel is (y-pos_y)*width + (x-pos_x). Index p is stored in bitmap word p/32, at bit p%32. Bitmap word k is written at `cfg_addr` = 32+k.
- R8: With the blink bit (register 0, bit 1) set, visibility inverts on every P-th `frame_start` pulse. P comes from register 0, bits 15:8, and a P of 0 acts as 1. Visibility starts as shown when blinking is turned on.
- R9: With the blink bit clear, `frame_start` has no effect and an enabled cursor is always shown.
- R10: Width (register 2, bits 5:0) and height (register 2, bits 13:8) saturate to 32 when written larger. A width or height of 0 draws nothing.
- R11: Position is x in register 1, bits 10:0, and y in register 1, bits 25:16. Writes to `cfg_addr` 4 to 31 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Register index (0-3) or bitmap word (32+k) |
| cfg_wdata | input | 32 | Write data |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| pix_valid | input | 1 | Raster pixel strobe |
| pix_x | input | 11 | Raster column |
| pix_y | input | 10 | Raster row |
| pix_in | input | 24 | Underlying composited RGB pixel |
| out_valid | output | 1 | Delayed pixel strobe |
| out_pix | output | 24 | Final RGB pixel |

## Verification
The bench probes the inclusive and exclusive edges of the window on all four sides. An off-by-one comparison there would paint a stray column or row, or drop the last one. A single-bit bitmap pattern away from row 0 exposes a wrong row stride or a swapped word/bit split, because the colour would appear at the wrong pixel. Oversized and zero sizes test saturation, since a design that truncates instead would draw a much narrower cursor or wrap its addresses. Blink runs with periods 3 and 0 catch a timer that toggles one frame early or late, or stalls when the period is 0. Writes to reserved addresses check that the control register has no aliases.

// File: rtl/cursor_pkg.sv
// Shared sizes and the configuration record of the cursor overlay.
// Assumes the bitmap depth is a multiple of the bus width.
package cursor_pkg;
    localparam int CUR_MAX   = 32;
    localparam int X_W       = 11;
    localparam int Y_W       = 10;
    localparam int SZ_W      = $clog2(CUR_MAX + 1);
    localparam int RGB_W     = 24;
    localparam int PER_W     = 8;
    localparam int BUS_W     = 32;
    localparam int BM_DEPTH  = CUR_MAX * CUR_MAX;
    localparam int BM_AW     = $clog2(BM_DEPTH);
    localparam int BM_WORDS  = BM_DEPTH / BUS_W;
    localparam int WIDX_W    = $clog2(BM_WORDS);
    localparam int CFG_AW    = WIDX_W + 1;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_POS  = 2'd1,
        REG_SIZE = 2'd2,
        REG_RGB  = 2'd3
    } cfg_reg_e;

    typedef struct packed {
        logic             enable;
        logic             blink_en;
        logic [PER_W-1:0] period;
        logic [X_W-1:0]   pos_x;
        logic [Y_W-1:0]   pos_y;
        logic [SZ_W-1:0]  width;
        logic [SZ_W-1:0]  height;
        logic [RGB_W-1:0] rgb;
    } cursor_cfg_t;
endpackage

// File: rtl/cursor_cfg_regs.sv
// Configuration decoder: holds the control, position, size and colour
// registers and steers bitmap word writes to the bitmap store.
// Assumes the upper half of the address space is the bitmap.
module cursor_cfg_regs
    import cursor_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [CFG_AW-1:0]  addr,
    input  logic [BUS_W-1:0]   wdata,
    output cursor_cfg_t        cfg,
    output logic               bm_we,
    output logic [WIDX_W-1:0]  bm_widx,
    output logic [BUS_W-1:0]   bm_wdata
);
    localparam logic [SZ_W-1:0] SZ_MAX = SZ_W'(CUR_MAX);

    logic              is_bitmap;
    logic              is_reg;
    logic [1:0]        reg_idx;
    logic [SZ_W-1:0]   new_w;
    logic [SZ_W-1:0]   new_h;
    logic              unused_bits;

    // Clamp a raw size field to the largest supported cursor side.
    function automatic logic [SZ_W-1:0] clamp_size(input logic [SZ_W-1:0] v);
        return (v > SZ_MAX) ? SZ_MAX : v;
    endfunction

    // Split the address into register and bitmap spaces.
    always_comb begin
        is_bitmap = addr[CFG_AW-1];
        reg_idx   = addr[1:0];
        is_reg    = !addr[CFG_AW-1] && (addr[CFG_AW-2:2] == '0);
        new_w     = clamp_size(wdata[SZ_W-1:0]);
        new_h     = clamp_size(wdata[8+SZ_W-1:8]);
    end

    assign unused_bits = ^{wdata[BUS_W-1:26], wdata[15:14], wdata[7:SZ_W]};

    // Bitmap words go straight through to the store.
    assign bm_we    = we && is_bitmap;
    assign bm_widx  = addr[WIDX_W-1:0];
    assign bm_wdata = wdata;

    // Register file update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we && is_reg) begin
            unique case (cfg_reg_e'(reg_idx))
                REG_CTRL: begin
                    cfg.enable   <= wdata[0];
                    cfg.blink_en <= wdata[1];
                    cfg.period   <= wdata[8+PER_W-1:8];
                end
                REG_POS: begin
                    cfg.pos_x <= wdata[X_W-1:0];
                    cfg.pos_y <= wdata[16+Y_W-1:16];
                end
                REG_SIZE: begin
                    cfg.width  <= new_w;
                    cfg.height <= new_h;
                end
                REG_RGB: cfg.rgb <= wdata[RGB_W-1:0];
                default: ;
            endcase
        end
    end

    AST_SIZE_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.width <= SZ_MAX) && (cfg.height <= SZ_MAX)); // R10
endmodule

// File: rtl/cursor_bitmap.sv
// One-bit-per-pixel cursor store: word-wide writes, single-bit
// registered reads. Contents are not reset; software loads them.
module cursor_bitmap
    import cursor_pkg::*;
#(
    parameter int DEPTH = BM_DEPTH,
    parameter int WORD  = BUS_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [WIDX_W-1:0]        widx,
    input  logic [WORD-1:0]          wdata,
    input  logic                     rd_en,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic                     rd_bit
);
    localparam int WORDS = DEPTH / WORD;
    localparam int WB    = $clog2(WORD);
    localparam int AW    = $clog2(DEPTH);

    logic [WORD-1:0] mem [WORDS];

    // One write port per word row.
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (we && (widx == WIDX_W'(w)))
                mem[w] <= wdata;
        end
    end

    // Registered single-bit read; reads as 0 when not selected.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_bit <= 1'b0;
        else if (rd_en)
            rd_bit <= mem[rd_addr[AW-1:WB]][rd_addr[WB-1:0]];
        else
            rd_bit <= 1'b0;
    end
endmodule

// File: rtl/cursor_blink.sv
// Blink timer: counts frame-start pulses and inverts visibility on
// every period-th pulse. Held shown and at count 0 while blink is off.
module cursor_blink
    import cursor_pkg::*;
#(
    parameter int PW = PER_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          blink_en,
    input  logic [PW-1:0] period,
    output logic          shown
);
    logic [PW-1:0] frame_cnt;
    logic          wrap;

    // A period of 0 wraps on every pulse, like a period of 1.
    assign wrap = ({1'b0, frame_cnt} + (PW+1)'(1)) >= {1'b0, period};

    // Frame counter and visibility toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !blink_en) begin
            frame_cnt <= '0;
            shown     <= 1'b1;
        end else if (frame_start) begin
            if (wrap) begin
                frame_cnt <= '0;
                shown     <= !shown;
            end else begin
                frame_cnt <= frame_cnt + PW'(1);
            end
        end
    end

    AST_BLINK_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !blink_en |=> shown); // R9
    AST_BLINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_en && !frame_start) |=> (shown == $past(shown))); // R8
endmodule

// File: rtl/cursor_window.sv
// Window test and bitmap addressing: flags raster positions inside the
// cursor rectangle and forms the row-major bitmap index.
// Assumes width and height never exceed the supported maximum.
module cursor_window
    import cursor_pkg::*;
(
    input  logic [X_W-1:0]   pix_x,
    input  logic [Y_W-1:0]   pix_y,
    input  logic [X_W-1:0]   pos_x,
    input  logic [Y_W-1:0]   pos_y,
    input  logic [SZ_W-1:0]  width,
    input  logic [SZ_W-1:0]  height,
    output logic             hit,
    output logic [BM_AW-1:0] addr
);
    localparam int LW = 2 * SZ_W;

    logic [X_W:0]    x_end;
    logic [Y_W:0]    y_end;
    logic            in_x;
    logic            in_y;
    logic [SZ_W-1:0] col;
    logic [SZ_W-1:0] row;
    logic [LW-1:0]   lin;

    // Bounds compare with one spare bit so the end never wraps.
    always_comb begin
        x_end = {1'b0, pos_x} + (X_W+1)'(width);
        y_end = {1'b0, pos_y} + (Y_W+1)'(height);
        in_x  = (pix_x >= pos_x) && ({1'b0, pix_x} < x_end);
        in_y  = (pix_y >= pos_y) && ({1'b0, pix_y} < y_end);
        hit   = in_x && in_y;
    end

    // Cursor-local coordinates and row-major bit index.
    always_comb begin
        col  = SZ_W'(pix_x - pos_x);
        row  = SZ_W'(pix_y - pos_y);
        lin  = LW'(row) * LW'(width) + LW'(col);
        addr = BM_AW'(lin);
    end
endmodule

// File: rtl/cursor_overlay.sv
// Cursor overlay top: stage 1 tests the window and reads the bitmap,
// stage 2 replaces the pixel with the cursor colour where drawn.
// Assumes frame_start is a single-cycle pulse per frame.
module cursor_overlay
    import cursor_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [BUS_W-1:0]  cfg_wdata,
    input  logic              frame_start,
    input  logic              pix_valid,
    input  logic [X_W-1:0]    pix_x,
    input  logic [Y_W-1:0]    pix_y,
    input  logic [RGB_W-1:0]  pix_in,
    output logic              out_valid,
    output logic [RGB_W-1:0]  out_pix
);
    cursor_cfg_t       cfg;
    logic              bm_we;
    logic [WIDX_W-1:0] bm_widx;
    logic [BUS_W-1:0]  bm_wdata;
    logic              shown;
    logic              win_hit;
    logic [BM_AW-1:0]  win_addr;
    logic              bm_bit;
    logic              s1_valid;
    logic              s1_show;
    logic [RGB_W-1:0]  s1_pix;

    cursor_cfg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .cfg      (cfg),
        .bm_we    (bm_we),
        .bm_widx  (bm_widx),
        .bm_wdata (bm_wdata)
    );

    cursor_blink #(.PW(PER_W)) u_blink (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .blink_en    (cfg.blink_en),
        .period      (cfg.period),
        .shown       (shown)
    );

    cursor_window u_win (
        .pix_x  (pix_x),
        .pix_y  (pix_y),
        .pos_x  (cfg.pos_x),
        .pos_y  (cfg.pos_y),
        .width  (cfg.width),
        .height (cfg.height),
        .hit    (win_hit),
        .addr   (win_addr)
    );

    cursor_bitmap #(.DEPTH(BM_DEPTH), .WORD(BUS_W)) u_bm (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (bm_we),
        .widx    (bm_widx),
        .wdata   (bm_wdata),
        .rd_en   (win_hit),
        .rd_addr (win_addr),
        .rd_bit  (bm_bit)
    );

    // Stage 1: capture strobe, underlying pixel and the draw decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_show  <= 1'b0;
            s1_pix   <= '0;
        end else begin
            s1_valid <= pix_valid;
            s1_show  <= win_hit && cfg.enable && shown;
            s1_pix   <= pix_in;
        end
    end

    // Stage 2: substitute the cursor colour where the bitmap bit is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= s1_valid;
            out_pix   <= (s1_show && bm_bit) ? cfg.rgb : s1_pix;
        end
    end

    AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> out_valid); // R2
    AST_DRAW_RGB: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_show && bm_bit) |=> (out_pix == $past(cfg.rgb))); // R3
    AST_CLEAR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_show && !bm_bit) |=> (out_pix == $past(s1_pix))); // R4
    AST_PASS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_show |=> (out_pix == $past(s1_pix))); // R6
endmodule

// File: tb/sim_cursor_overlay.sv
`timescale 1ns/1ps
module sim_cursor_overlay;
    import cursor_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [CFG_AW-1:0] cfg_addr = '0;
    logic [BUS_W-1:0]  cfg_wdata = '0;
    logic              frame_start = 1'b0;
    logic              pix_valid = 1'b0;
    logic [X_W-1:0]    pix_x = '0;
    logic [Y_W-1:0]    pix_y = '0;
    logic [RGB_W-1:0]  pix_in = '0;
    logic              out_valid;
    logic [RGB_W-1:0]  out_pix;

    int checks = 0;
    int fails  = 0;

    bit [BM_DEPTH-1:0] bm_m;
    bit en_m, blink_m, vis_m;
    int per_m, cnt_m, px_m, py_m, w_m, h_m;
    logic [RGB_W-1:0] rgb_m;

    always #4 clk = ~clk;

    cursor_overlay u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start), .pix_valid(pix_valid),
        .pix_x(pix_x), .pix_y(pix_y), .pix_in(pix_in),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    function automatic int sat_sz(input int v);
        return (v > CUR_MAX) ? CUR_MAX : v;
    endfunction

    function automatic logic [RGB_W-1:0] expect_pix(input int x, input int y,
                                                    input logic [RGB_W-1:0] p);
        int col = x - px_m;
        int row = y - py_m;
        if (!en_m) return p;
        if (col < 0 || col >= w_m || row < 0 || row >= h_m) return p;
        if (!bm_m[row * w_m + col]) return p;
        if (blink_m && !vis_m) return p;
        return rgb_m;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = CFG_AW'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_ctrl(input bit en, input bit bl, input int per);
        wr(0, {16'd0, 8'(per), 6'd0, bl, en});
        en_m = en; blink_m = bl; per_m = per;
        if (!bl) begin vis_m = 1'b1; cnt_m = 0; end
    endtask

    task automatic set_pos(input int x, input int y);
        wr(1, {6'd0, 10'(y), 5'd0, 11'(x)});
        px_m = x; py_m = y;
    endtask

    task automatic set_size(input int w, input int h);
        wr(2, {18'd0, 6'(h), 2'd0, 6'(w)});
        w_m = sat_sz(w); h_m = sat_sz(h);
    endtask

    task automatic set_word(input int k, input logic [31:0] d);
        wr(32 + k, d);
        for (int b = 0; b < BUS_W; b++) bm_m[k * BUS_W + b] = d[b];
    endtask

    task automatic frame();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        if (blink_m) begin
            if (cnt_m + 1 >= per_m) begin cnt_m = 0; vis_m = !vis_m; end
            else cnt_m++;
        end
    endtask

    task automatic pixel(input string req, input int x, input int y,
                         input logic [RGB_W-1:0] p);
        @(negedge clk);
        pix_x = X_W'(x); pix_y = Y_W'(y); pix_in = p; pix_valid = 1'b1;
        @(negedge clk);
        pix_valid = 1'b0;
        @(negedge clk);
        check(req, 32'(out_pix), 32'(expect_pix(x, y, p)));
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual timeout expected finish");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        en_m = 0; blink_m = 0; vis_m = 1; per_m = 0; cnt_m = 0;
        px_m = 0; py_m = 0; w_m = 0; h_m = 0; rgb_m = '0; bm_m = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid", 32'(out_valid), 32'd0);
        check("R1 out_pix", 32'(out_pix), 32'd0);
        rst_n = 1'b1;
        for (int k = 0; k < BM_WORDS; k++) set_word(k, $urandom());
        set_word(0, bm_m[31:0] | 32'h1);
        set_pos(100, 50);
        set_size(20, 12);
        rgb_m = 24'hF0A055;
        wr(3, {8'd0, rgb_m});
        // R1: still disabled after configuration
        pixel("R1 disabled after reset", 100, 50, 24'h123456);

        set_ctrl(1, 0, 0);
        // R2: latency and valid strobe
        @(negedge clk);
        pix_x = 11'd100; pix_y = 10'd50; pix_in = 24'h010203; pix_valid = 1'b1;
        @(negedge clk); pix_valid = 1'b0;
        check("R2 valid not early", 32'(out_valid), 32'd0);
        @(negedge clk);
        check("R2 valid at two edges", 32'(out_valid), 32'd1);
        check("R3 colour at corner", 32'(out_pix), 32'(rgb_m));
        @(negedge clk);
        check("R2 valid drops", 32'(out_valid), 32'd0);

        // R5: window edges
        pixel("R5 last column", 119, 61, 24'h0000AA);
        pixel("R5 right edge", 120, 50, 24'h0000BB);
        pixel("R5 left edge", 99, 50, 24'h0000CC);
        pixel("R5 bottom edge", 100, 62, 24'h0000DD);
        pixel("R5 top edge", 100, 49, 24'h0000EE);

        // R7: single bit at row 2 column 5 -> index 45, word 1 bit 13
        set_word(1, 32'h0000_2000);
        pixel("R7 mapped bit", 105, 52, 24'h111111);
        check("R7 mapped bit drawn", 32'(expect_pix(105, 52, 24'h111111)), 32'(rgb_m));
        pixel("R4 clear neighbour", 106, 52, 24'h222222);
        check("R4 clear neighbour passes", 32'(expect_pix(106, 52, 24'h222222)), 32'h222222);

        // R11: reserved addresses leave the control register alone
        wr(4, 32'h0);
        wr(31, 32'h0);
        pixel("R11 reserved write ignored", 100, 50, 24'h333333);
        set_pos(300, 200);
        pixel("R11 moved cursor", 300, 200, 24'h444444);
        pixel("R11 old spot", 100, 50, 24'h555555);
        set_pos(100, 50);

        // R3 R4 R5: random pixels around the window
        for (int i = 0; i < 600; i++) begin
            int x = 90 + int'($urandom_range(0, 40));
            int y = 45 + int'($urandom_range(0, 22));
            pixel("R3 R4 R5 random", x, y, 24'($urandom()));
        end

        // R6: disabled cursor passes everything
        set_ctrl(0, 0, 0);
        for (int i = 0; i < 60; i++)
            pixel("R6 disabled", 100 + int'($urandom_range(0, 19)),
                  50 + int'($urandom_range(0, 11)), 24'($urandom()));
        set_ctrl(1, 0, 0);

        // R10: saturation and zero size
        set_size(63, 40);
        pixel("R10 saturated last column", 131, 81, 24'h666666);
        pixel("R10 beyond saturated width", 132, 50, 24'h777777);
        pixel("R10 beyond saturated height", 100, 82, 24'h888888);
        for (int i = 0; i < 200; i++)
            pixel("R10 saturated random", 95 + int'($urandom_range(0, 42)),
                  45 + int'($urandom_range(0, 42)), 24'($urandom()));
        set_size(0, 12);
        pixel("R10 zero width", 100, 50, 24'h999999);
        set_size(20, 0);
        pixel("R10 zero height", 100, 50, 24'hAAAAAA);
        set_size(20, 12);

        // R9: frames do nothing with blink off
        repeat (3) frame();
        pixel("R9 steady", 100, 50, 24'hBBBBBB);

        // R8: blink with period 3 then period 0
        set_ctrl(1, 1, 3);
        pixel("R8 starts shown", 100, 50, 24'hCCCCCC);
        for (int f = 0; f < 9; f++) begin
            frame();
            pixel("R8 period 3", 100, 50, 24'hCCCCCC);
        end
        set_ctrl(1, 0, 0);
        set_ctrl(1, 1, 0);
        for (int f = 0; f < 4; f++) begin
            frame();
            pixel("R8 period 0", 100, 50, 24'hDDDDDD);
        end
        set_ctrl(1, 0, 0);
        pixel("R9 blink off shown", 100, 50, 24'hEEEEEE);

        summary();
        $finish;
    end
endmodule